// File: doc/BRIEF.md
# Sample Timing Configuration Sequencer

This block programs the sampling and drive timing of a card-interface clock generator for one speed mode. A single-cycle start strobe launches it. With the strobe it takes the controller kind (SD card or SDIO), a 4-bit speed-mode index, a 5-bit sample phase and a flag that asks for the mode's default phase. The block then issues a fixed series of register writes on a simple write port (address, data, strobe) and pulses `done` when the new timing has had time to settle.

On start, the block looks up a small per-kind table of drive phase, sample delay and sample-phase window for the mode. It picks the sample phase, either the given one or the truncated midpoint of the window. From that phase it derives two flags: a shift-enable and a use-delay. The write series runs in this order:
- gate the generated clock off;
- wait a short settle time;
- program the timing word;
- program the shift flag;
- re-enable the clock with its divider and the use-delay bit;
- wait a long settle time before `done`.

All wait lengths follow from a clock-frequency parameter. A caller drives `start` and waits for `done` before it relies on the new timing.

Top module: `samp_timing_seq`

## Requirements
- R1: Out of reset, and while idle, `wrEn`, `busy` and `done` are low. No write is issued without a start.
- R2: In the cycle right after `start` is sampled while idle, the block writes 0 to the clock-control register at address 0x08, which gates the clock off. `busy` is high from that cycle until `done` has pulsed.
- R3: The write to the timing register follows the gating write after exactly SETTLE_US*CLK_HZ/1e6 idle cycles, with `wrEn` low throughout that gap.
- R4: The timing register at address 0x0C receives the sample phase in bits 20:16, the drive phase in bits 25:21 and the sample delay in bits 30:26. All other bits are zero.
- R5: In the cycle right after the timing write, the block writes the shift-enable flag to bit 0 of address 0x10, with bits 31:1 zero.
- R6: In the cycle right after the shift write, the block writes the clock-control register at 0x08 with these bits: 16 set (clock enable), 11:8 equal to 7 (divider), 13 equal to the use-delay flag, all others zero.
- R7: `done` is a one-cycle pulse that comes HOLD_US*CLK_HZ/1e6 idle cycles after the final write. `busy` is low in the cycle after `done`.
- R8: When the default flag is set, the sample phase is (window max + window min)/2, truncated. When the flag is clear, the given phase is used unchanged.
- R9: Table entries are (drive, delay, max, min). Modes 7 to 15 give all zeros for both kinds.
  - SD: mode 0 (7,0,15,15), 1 (6,0,4,4), 2 (6,0,3,3), 3 (6,0,15,15), 4 (6,0,2,2), 5 (4,0,11,0), 6 (6,4,15,0).
  - SDIO: mode 0 (7,0,15,15), 1 all zero, 2 and 3 (6,0,15,15), 4 (6,0,0,0), 5 (4,0,12,0), 6 (5,4,15,0).
  - SD is `isSdio`=0.
- R10: Shift-enable is 1 only in modes 5 and 6, with the phase in 4..12 inclusive. Use-delay is 1 only in mode 6, with the phase in 11..14 inclusive.
- R11: A `start` that arrives while `busy` is high is ignored. The run in progress keeps its captured settings, and it produces exactly four writes and one `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe, one cycle |
| isSdio | input | 1 | Controller kind: 0 SD card, 1 SDIO |
| modeIdx | input | 4 | Speed-mode index |
| phaseIn | input | 5 | Requested sample phase |
| useDefault | input | 1 | Use the mode's default phase |
| wrEn | output | 1 | Register write strobe |
| wrAddr | output | 8 | Register write address |
| wrData | output | 32 | Register write data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A wrong table entry or a wrong flag decision shows up as a bad field in the timing write or in the final clock write. These come within a few cycles of the end of the short settle, well before `done`. A bad state transition or a miscounted wait shows up as a missing, repeated or reordered write, or as a shifted gap between writes. Both are measured in cycles from the start strobe. A start that wrongly restarts the sequence shows up as a second gating write, at once, in the cycle after the stray strobe.

// File: rtl/samp_timing_pkg.sv
package samp_timing_pkg;

  localparam logic [7:0] ADDR_CLK_CTRL   = 8'h08;
  localparam logic [7:0] ADDR_EXT_TIMING = 8'h0C;
  localparam logic [7:0] ADDR_SHIFT_EN   = 8'h10;

  localparam logic [3:0] MODE_SDR50  = 4'd5;
  localparam logic [3:0] MODE_SDR104 = 4'd6;

  localparam logic [4:0] SHIFT_LO = 5'd4;
  localparam logic [4:0] SHIFT_HI = 5'd12;
  localparam logic [4:0] DLY_LO   = 5'd11;
  localparam logic [4:0] DLY_HI   = 5'd14;

  localparam logic [3:0] CLK_DIV_VAL = 4'd7;

  typedef enum logic [1:0] {W_GATE, W_EXT, W_SHIFT, W_CLK} wordSel_e;

  typedef struct packed {
    logic     capture;
    logic     wrEn;
    wordSel_e sel;
  } seqCmd_t;

  typedef struct packed {
    logic [4:0] drv;
    logic [4:0] dly;
    logic [4:0] pmax;
    logic [4:0] pmin;
  } modeEnt_t;

  function automatic modeEnt_t mode_lookup(input logic isSdio, input logic [3:0] mode);
    modeEnt_t e;
    e = '0;
    if (!isSdio) begin
      case (mode)
        4'd0: e = {5'd7, 5'd0, 5'd15, 5'd15};
        4'd1: e = {5'd6, 5'd0, 5'd4,  5'd4};
        4'd2: e = {5'd6, 5'd0, 5'd3,  5'd3};
        4'd3: e = {5'd6, 5'd0, 5'd15, 5'd15};
        4'd4: e = {5'd6, 5'd0, 5'd2,  5'd2};
        4'd5: e = {5'd4, 5'd0, 5'd11, 5'd0};
        4'd6: e = {5'd6, 5'd4, 5'd15, 5'd0};
        default: e = '0;
      endcase
    end else begin
      case (mode)
        4'd0: e = {5'd7, 5'd0, 5'd15, 5'd15};
        4'd2: e = {5'd6, 5'd0, 5'd15, 5'd15};
        4'd3: e = {5'd6, 5'd0, 5'd15, 5'd15};
        4'd4: e = {5'd6, 5'd0, 5'd0,  5'd0};
        4'd5: e = {5'd4, 5'd0, 5'd12, 5'd0};
        4'd6: e = {5'd5, 5'd4, 5'd15, 5'd0};
        default: e = '0;
      endcase
    end
    return e;
  endfunction

endpackage

// File: rtl/samp_timing_path.sv
module samp_timing_path
  import samp_timing_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  seqCmd_t     cmd,
  input  logic        isSdio,
  input  logic [3:0]  modeIdx,
  input  logic [4:0]  phaseIn,
  input  logic        useDefault,
  output logic [7:0]  wrAddr,
  output logic [31:0] wrData
);

  modeEnt_t   ent;
  logic [5:0] winSum;
  logic [4:0] phaseNext;
  logic       inShiftWin;
  logic       inDlyWin;
  logic       shiftNext;
  logic       useDlyNext;

  logic [4:0] phaseR;
  logic [4:0] drvR;
  logic [4:0] dlyR;
  logic       shiftR;
  logic       useDlyR;

  always_comb begin
    ent        = mode_lookup(isSdio, modeIdx);
    winSum     = {1'b0, ent.pmax} + {1'b0, ent.pmin};
    phaseNext  = useDefault ? winSum[5:1] : phaseIn;
    inShiftWin = (phaseNext >= SHIFT_LO) && (phaseNext <= SHIFT_HI);
    inDlyWin   = (phaseNext >= DLY_LO) && (phaseNext <= DLY_HI);
    shiftNext  = ((modeIdx == MODE_SDR50) || (modeIdx == MODE_SDR104)) && inShiftWin;
    useDlyNext = (modeIdx == MODE_SDR104) && inDlyWin;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseR  <= '0;
      drvR    <= '0;
      dlyR    <= '0;
      shiftR  <= 1'b0;
      useDlyR <= 1'b0;
    end else if (cmd.capture) begin
      phaseR  <= phaseNext;
      drvR    <= ent.drv;
      dlyR    <= ent.dly;
      shiftR  <= shiftNext;
      useDlyR <= useDlyNext;
    end
  end

  always_comb begin
    wrAddr = '0;
    wrData = '0;
    if (cmd.wrEn) begin
      case (cmd.sel)
        W_GATE: begin
          wrAddr = ADDR_CLK_CTRL;
          wrData = '0;
        end
        W_EXT: begin
          wrAddr = ADDR_EXT_TIMING;
          wrData = {1'b0, dlyR, drvR, phaseR, 16'h0000};
        end
        W_SHIFT: begin
          wrAddr = ADDR_SHIFT_EN;
          wrData = {31'd0, shiftR};
        end
        default: begin
          wrAddr = ADDR_CLK_CTRL;
          wrData = {15'd0, 1'b1, 2'b00, useDlyR, 1'b0, CLK_DIV_VAL, 8'h00};
        end
      endcase
    end
  end

  // Captured flags must agree with the captured phase (R10).
  p_usedly_window_r10: assert property (@(posedge clk) disable iff (!rstN)
    useDlyR |-> (phaseR >= DLY_LO) && (phaseR <= DLY_HI));
  p_shift_window_r10: assert property (@(posedge clk) disable iff (!rstN)
    shiftR |-> (phaseR >= SHIFT_LO) && (phaseR <= SHIFT_HI));

endmodule

// File: rtl/samp_timing_ctrl.sv
module samp_timing_ctrl
  import samp_timing_pkg::*;
#(
  parameter int SHORT_CYC = 300,
  parameter int LONG_CYC  = 50000,
  localparam int CNT_W = $clog2(LONG_CYC + 1)
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  output seqCmd_t cmd,
  output logic    busy,
  output logic    done
);

  typedef enum logic [2:0] {
    S_IDLE, S_GATE, S_SETTLE, S_EXT, S_SHIFT, S_CLK, S_HOLD, S_DONE
  } state_e;

  state_e     state;
  logic [CNT_W-1:0] waitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      waitCnt <= '0;
    end else begin
      case (state)
        S_IDLE:   if (start) state <= S_GATE;
        S_GATE: begin
          waitCnt <= CNT_W'(SHORT_CYC - 1);
          state   <= S_SETTLE;
        end
        S_SETTLE: if (waitCnt == '0) state <= S_EXT;
                  else waitCnt <= waitCnt - 1'b1;
        S_EXT:    state <= S_SHIFT;
        S_SHIFT:  state <= S_CLK;
        S_CLK: begin
          waitCnt <= CNT_W'(LONG_CYC - 1);
          state   <= S_HOLD;
        end
        S_HOLD:   if (waitCnt == '0) state <= S_DONE;
                  else waitCnt <= waitCnt - 1'b1;
        default:  state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd.capture = (state == S_IDLE) && start;
    cmd.wrEn    = 1'b0;
    cmd.sel     = W_GATE;
    case (state)
      S_GATE:  begin cmd.wrEn = 1'b1; cmd.sel = W_GATE;  end
      S_EXT:   begin cmd.wrEn = 1'b1; cmd.sel = W_EXT;   end
      S_SHIFT: begin cmd.wrEn = 1'b1; cmd.sel = W_SHIFT; end
      S_CLK:   begin cmd.wrEn = 1'b1; cmd.sel = W_CLK;   end
      default: ;
    endcase
    busy = (state != S_IDLE);
    done = (state == S_DONE);
  end

  // Wait counter never starts a settle window above its load value (R3, R7).
  p_wait_bound_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_HOLD) |-> (waitCnt < CNT_W'(LONG_CYC)));

endmodule

// File: rtl/samp_timing_seq.sv
module samp_timing_seq
  import samp_timing_pkg::*;
#(
  parameter int CLK_HZ    = 50_000_000,
  parameter int SETTLE_US = 6,
  parameter int HOLD_US   = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        isSdio,
  input  logic [3:0]  modeIdx,
  input  logic [4:0]  phaseIn,
  input  logic        useDefault,
  output logic        wrEn,
  output logic [7:0]  wrAddr,
  output logic [31:0] wrData,
  output logic        busy,
  output logic        done
);

  localparam int CYC_PER_US = CLK_HZ / 1_000_000;
  localparam int SHORT_CYC  = SETTLE_US * CYC_PER_US;
  localparam int LONG_CYC   = HOLD_US * CYC_PER_US;

  seqCmd_t cmd;

  samp_timing_ctrl #(
    .SHORT_CYC(SHORT_CYC),
    .LONG_CYC (LONG_CYC)
  ) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .cmd  (cmd),
    .busy (busy),
    .done (done)
  );

  samp_timing_path u_path (
    .clk       (clk),
    .rstN      (rstN),
    .cmd       (cmd),
    .isSdio    (isSdio),
    .modeIdx   (modeIdx),
    .phaseIn   (phaseIn),
    .useDefault(useDefault),
    .wrAddr    (wrAddr),
    .wrData    (wrData)
  );

  assign wrEn = cmd.wrEn;

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !wrEn);
  p_ext_then_shift_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_EXT_TIMING) |=> (wrEn && wrAddr == ADDR_SHIFT_EN));
  p_shift_then_clk_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == ADDR_SHIFT_EN) |=> (wrEn && wrAddr == ADDR_CLK_CTRL && wrData[16]));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));
  p_no_restart_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> !(wrEn && wrAddr == ADDR_CLK_CTRL && wrData == 32'd0));

endmodule

// File: tb/samp_timing_seq_bench.sv
module samp_timing_seq_bench;

  // Scaled clock-frequency parameter keeps waits short: 2 cycles per microsecond.
  localparam int CLK_HZ    = 2_000_000;
  localparam int SETTLE_US = 6;
  localparam int HOLD_US   = 1000;
  localparam int SHORT_CYC = SETTLE_US * (CLK_HZ / 1_000_000);
  localparam int LONG_CYC  = HOLD_US * (CLK_HZ / 1_000_000);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        isSdio = 1'b0;
  logic [3:0]  modeIdx = '0;
  logic [4:0]  phaseIn = '0;
  logic        useDefault = 1'b0;
  logic        wrEn;
  logic [7:0]  wrAddr;
  logic [31:0] wrData;
  logic        busy;
  logic        done;

  always #10 clk = ~clk;

  samp_timing_seq #(
    .CLK_HZ(CLK_HZ), .SETTLE_US(SETTLE_US), .HOLD_US(HOLD_US)
  ) u_samp_timing_seq (
    .clk(clk), .rstN(rstN), .start(start), .isSdio(isSdio), .modeIdx(modeIdx),
    .phaseIn(phaseIn), .useDefault(useDefault), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .busy(busy), .done(done)
  );

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Write and done monitor, sampled mid-cycle.
  logic [7:0]  mAddr [256];
  logic [31:0] mData [256];
  int          mCyc  [256];
  int totWr = 0;
  int totDone = 0;
  int lastDoneCyc = 0;
  always @(negedge clk) begin
    if (wrEn) begin
      mAddr[totWr % 256] <= wrAddr;
      mData[totWr % 256] <= wrData;
      mCyc[totWr % 256]  <= cyc;
      totWr <= totWr + 1;
    end
    if (done) begin
      totDone <= totDone + 1;
      lastDoneCyc <= cyc;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Fields: kind, mode, useDef, phase, expPhase, expDrv, expDly, expShift, expUseDly
  localparam int NVEC = 20;
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b0, 4'd0,  1'b1, 5'd0,  5'd15, 5'd7, 5'd0, 1'b0, 1'b0},
    {1'b0, 4'd5,  1'b1, 5'd0,  5'd5,  5'd4, 5'd0, 1'b1, 1'b0},
    {1'b0, 4'd6,  1'b1, 5'd0,  5'd7,  5'd6, 5'd4, 1'b1, 1'b0},
    {1'b0, 4'd6,  1'b0, 5'd12, 5'd12, 5'd6, 5'd4, 1'b1, 1'b1},
    {1'b0, 4'd6,  1'b0, 5'd13, 5'd13, 5'd6, 5'd4, 1'b0, 1'b1},
    {1'b0, 4'd6,  1'b0, 5'd14, 5'd14, 5'd6, 5'd4, 1'b0, 1'b1},
    {1'b0, 4'd6,  1'b0, 5'd15, 5'd15, 5'd6, 5'd4, 1'b0, 1'b0},
    {1'b0, 4'd6,  1'b0, 5'd3,  5'd3,  5'd6, 5'd4, 1'b0, 1'b0},
    {1'b0, 4'd5,  1'b0, 5'd4,  5'd4,  5'd4, 5'd0, 1'b1, 1'b0},
    {1'b0, 4'd5,  1'b0, 5'd12, 5'd12, 5'd4, 5'd0, 1'b1, 1'b0},
    {1'b0, 4'd5,  1'b0, 5'd13, 5'd13, 5'd4, 5'd0, 1'b0, 1'b0},
    {1'b0, 4'd6,  1'b0, 5'd11, 5'd11, 5'd6, 5'd4, 1'b1, 1'b1},
    {1'b0, 4'd6,  1'b0, 5'd10, 5'd10, 5'd6, 5'd4, 1'b1, 1'b0},
    {1'b0, 4'd4,  1'b0, 5'd8,  5'd8,  5'd6, 5'd0, 1'b0, 1'b0},
    {1'b1, 4'd5,  1'b1, 5'd0,  5'd6,  5'd4, 5'd0, 1'b1, 1'b0},
    {1'b1, 4'd6,  1'b1, 5'd0,  5'd7,  5'd5, 5'd4, 1'b1, 1'b0},
    {1'b1, 4'd4,  1'b1, 5'd9,  5'd0,  5'd6, 5'd0, 1'b0, 1'b0},
    {1'b0, 4'd1,  1'b1, 5'd0,  5'd4,  5'd6, 5'd0, 1'b0, 1'b0},
    {1'b0, 4'd12, 1'b1, 5'd0,  5'd0,  5'd0, 5'd0, 1'b0, 1'b0},
    {1'b0, 4'd2,  1'b1, 5'd20, 5'd3,  5'd6, 5'd0, 1'b0, 1'b0}
  };

  task automatic pulse_start(input logic k, input logic [3:0] m, input logic d, input logic [4:0] p);
    @(negedge clk);
    isSdio = k; modeIdx = m; useDefault = d; phaseIn = p;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input int doneBase);
    for (int n = 0; n < LONG_CYC + SHORT_CYC + 50; n++) begin
      @(negedge clk);
      if (totDone > doneBase) break;
    end
    @(negedge clk);
  endtask

  task automatic check_run(input int wrBase, input int doneBase, input int startCyc,
                           input logic [4:0] ePh, input logic [4:0] eDrv, input logic [4:0] eDly,
                           input logic eSh, input logic eUse);
    logic [31:0] expExt;
    logic [31:0] expClk;
    expExt = {1'b0, eDly, eDrv, ePh, 16'h0000};
    expClk = 32'h0001_0700 | (32'(eUse) << 13);
    check(totWr - wrBase == 4, "R11 write count", 32'(totWr - wrBase), 32'd4);
    check(totDone - doneBase == 1, "R7 done count", 32'(totDone - doneBase), 32'd1);
    check(mAddr[wrBase % 256] == 8'h08 && mData[wrBase % 256] == 32'd0, "R2 gate write",
          {mAddr[wrBase % 256], mData[wrBase % 256][23:0]}, 32'h0800_0000);
    check(mCyc[wrBase % 256] == startCyc + 1, "R2 gate timing",
          32'(mCyc[wrBase % 256] - startCyc), 32'd1);
    check(mCyc[(wrBase + 1) % 256] - mCyc[wrBase % 256] == SHORT_CYC + 1, "R3 settle gap",
          32'(mCyc[(wrBase + 1) % 256] - mCyc[wrBase % 256]), 32'(SHORT_CYC + 1));
    check(mAddr[(wrBase + 1) % 256] == 8'h0C, "R4 timing addr", 32'(mAddr[(wrBase + 1) % 256]), 32'h0C);
    check(mData[(wrBase + 1) % 256] == expExt, "R4 R8 R9 timing word", mData[(wrBase + 1) % 256], expExt);
    check(mAddr[(wrBase + 2) % 256] == 8'h10 && mCyc[(wrBase + 2) % 256] == mCyc[(wrBase + 1) % 256] + 1,
          "R5 shift addr/order", 32'(mAddr[(wrBase + 2) % 256]), 32'h10);
    check(mData[(wrBase + 2) % 256] == 32'(eSh), "R5 R10 shift flag", mData[(wrBase + 2) % 256], 32'(eSh));
    check(mAddr[(wrBase + 3) % 256] == 8'h08 && mCyc[(wrBase + 3) % 256] == mCyc[(wrBase + 2) % 256] + 1,
          "R6 clk addr/order", 32'(mAddr[(wrBase + 3) % 256]), 32'h08);
    check(mData[(wrBase + 3) % 256] == expClk, "R6 R10 clk word", mData[(wrBase + 3) % 256], expClk);
    check(lastDoneCyc - mCyc[(wrBase + 3) % 256] == LONG_CYC + 1, "R7 hold gap",
          32'(lastDoneCyc - mCyc[(wrBase + 3) % 256]), 32'(LONG_CYC + 1));
    check(!busy && !done, "R7 idle after done", {30'd0, busy, done}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!wrEn && !busy && !done, "R1 reset state", {29'd0, wrEn, busy, done}, 32'd0);
    rstN = 1'b1;
    repeat (10) @(negedge clk);
    check(totWr == 0 && !busy, "R1 idle no writes", 32'(totWr), 32'd0);

    for (int i = 0; i < NVEC; i++) begin
      int wb;
      int db;
      int sc;
      logic [27:0] v;
      v = VEC[i];
      wb = totWr; db = totDone;
      @(negedge clk);
      sc = cyc;
      isSdio = v[27]; modeIdx = v[26:23]; useDefault = v[22]; phaseIn = v[21:17];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy, "R2 busy after start", 32'(busy), 32'd1);
      wait_done(db);
      check_run(wb, db, sc, v[16:12], v[11:7], v[6:2], v[1], v[0]);
    end

    // Start strobes while busy are ignored (R11).
    begin
      int wb;
      int db;
      int sc;
      wb = totWr; db = totDone;
      @(negedge clk);
      sc = cyc;
      isSdio = 1'b0; modeIdx = 4'd6; useDefault = 1'b0; phaseIn = 5'd12;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (4) @(negedge clk);
      pulse_start(1'b1, 4'd0, 1'b1, 5'd0);
      repeat (40) @(negedge clk);
      pulse_start(1'b0, 4'd4, 1'b0, 5'd2);
      check(busy, "R11 still busy", 32'(busy), 32'd1);
      wait_done(db);
      check_run(wb, db, sc, 5'd12, 5'd6, 5'd4, 1'b1, 1'b1);
      repeat (20) @(negedge clk);
      check(totWr == wb + 4, "R11 no late restart", 32'(totWr - wb), 32'd4);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog all-R actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule